// File: doc/BRIEF.md
# Codec power and standby sequencer

This block is the control state machine that decides, for each direction of a voice codec, whether the path is powered down, in standby, waking up or live. It drives the output enable of the transmit serial data and its time-slot strobe, and it drives the receive signaling output together with that output's enable. Analog power gating is outside the block; `tx_act_o` and `rx_act_o` tell the rest of the chip which paths should be powered.

Each direction watches its own frame sync. A sync that stays low long enough puts that direction into standby. The first sync rising edge afterwards wakes it, and output resumes on the following frame. A power-down pin overrides everything. After reset or a power-down release, the transmit outputs stay blanked for a set number of frames. The transmit master clock is also watched, and the transmit outputs float when it stops toggling. All timeouts count `tick_i` pulses, which nominally come once per microsecond.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `rst_ni` is low, `tx_act_o`=0, `rx_act_o`=0, `tx_oe_o`=0, `sig_oe_o`=1 and `sig_o`=0.
- R2: When `pdn_drv_i`=1 and `pdn_i`=0, after the next clock edge `tx_act_o`=0, `rx_act_o`=0, `tx_oe_o`=0, `sig_oe_o`=1 and `sig_o`=0.
- R3: When `pdn_drv_i`=0 (pin undriven), the block behaves as if power-down is not requested, whatever `pdn_i` is.
- R4: Each clock with `tick_i`=1 advances a direction's timer while its sync is low; any sync edge clears it. With `tick_i` high every clock, a transmit sync that falls and stays low for D clocks leaves `tx_act_o`=0 and `tx_oe_o`=0 after those D clocks exactly when D >= STBY_TICKS+2.
- R5: Receive standby alone (receive sync low long enough, transmit still awake) gives `rx_act_o`=0 and `sig_oe_o`=0, and transmit keeps working.
- R6: When both directions are in standby, `tx_act_o`=0, `tx_oe_o`=0, `sig_oe_o`=1 and `sig_o`=0.
- R7: A clock with `tick_i`=0 does not advance any timer. A sync held low with no ticks never causes standby.
- R8: A direction in standby wakes at the first sync rising edge: `tx_act_o`=1 after that edge while `tx_oe_o` stays 0. `tx_oe_o` returns to 1 at the next sync rising edge.
- R9: After reset release or power-down release, `tx_oe_o` stays 0 until the (TX_BLANK_FRAMES+1)-th transmit sync rising edge and becomes 1 at that edge. The receive side goes live at its (RX_WAKE_FRAMES+1)-th rising edge.
- R10: If `tx_mclk_i` shows no edge for CLK_LOSS_TICKS ticks (after a CLK_SYNC_STAGES-flop synchronizer), `tx_oe_o` goes to 0 while `tx_act_o` stays 1. `tx_oe_o` returns once the clock toggles again.
- R11: While the receive direction is live, `sig_oe_o`=1 and `sig_o` equals `rx_sig_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low; acts as power-up |
| tick_i | input | 1 | Timebase strobe, one clock wide per tick |
| pdn_drv_i | input | 1 | 1 when the power-down pin is actively driven |
| pdn_i | input | 1 | Power-down pin level, low requests power-down |
| fs_tx_i | input | 1 | Transmit frame sync, synchronous to clk_i |
| fs_rx_i | input | 1 | Receive frame sync, synchronous to clk_i |
| tx_mclk_i | input | 1 | Transmit master clock, asynchronous, monitored for activity |
| rx_sig_i | input | 1 | Receive signaling value to present when live |
| tx_act_o | output | 1 | Transmit path awake (waking or live) |
| rx_act_o | output | 1 | Receive path awake (waking or live) |
| tx_oe_o | output | 1 | Output enable for transmit data and slot strobe |
| sig_o | output | 1 | Receive signaling output value |
| sig_oe_o | output | 1 | Output enable for sig_o |

## Verification
The assertions check on every cycle that power-down silences all outputs one edge later. They also check that an expired timer removes the direction's activity, that a direction goes live only on a sync rising edge, that the transmit enable rises only on a sync edge or on clock recovery, and that the signaling output floats only in receive-only standby. Only the bench's scenarios can show the exact standby threshold across a sweep of low durations, the frame count of the power-up blanking, the freeze of the timers when no tick arrives, and the recovery sequences.

// File: rtl/codec_pwr_seq_pkg.sv
package codec_pwr_seq_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_STBY = 2'd1,
    CH_WAKE = 2'd2,
    CH_LIVE = 2'd3
  } ch_state_e;
endpackage

// File: rtl/cseq_watch.sv
// Activity timer: counts ticks since the last edge of lvl_i.
module cseq_watch #(
  parameter int LIMIT       = 300000,
  parameter bit LOW_ONLY    = 1'b1,
  parameter int SYNC_STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic lvl_i,
  output logic rise_o,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [SYNC_STAGES:0] chain;
  assign chain[0] = lvl_i;

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain[g] <= 1'b0;
      else         chain[g] <= chain[g-1];
    end
  end

  logic lvl, prev_q, edge_s, cnt_en;
  logic [CW-1:0] cnt_q;

  assign lvl    = chain[SYNC_STAGES];
  assign edge_s = lvl ^ prev_q;
  assign rise_o = lvl & ~prev_q;
  assign cnt_en = LOW_ONLY ? ~lvl : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= lvl;
      if (edge_s)                             cnt_q <= '0;
      else if (tick_i && cnt_en && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
    end
  end

  // edge in the same cycle wins over expiry
  assign expired_o = (cnt_q == LIM) && !edge_s;

  p_cnt_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
  p_no_tick_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !edge_s) |=> $stable(cnt_q));
endmodule

// File: rtl/cseq_chan.sv
// Per-direction power state machine.
module cseq_chan
  import codec_pwr_seq_pkg::*;
#(
  parameter int WAKE_FRAMES = 0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pd_i,
  input  logic      rise_i,
  input  logic      expired_i,
  output ch_state_e state_o
);
  localparam int FW = $clog2(WAKE_FRAMES + 2);
  localparam logic [FW-1:0] WAKE_LOAD = FW'(WAKE_FRAMES + 1);
  localparam logic [FW-1:0] ONE = FW'(1);

  ch_state_e state_q, state_d;
  logic [FW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (pd_i) begin
      state_d = CH_OFF;
    end else begin
      unique case (state_q)
        CH_OFF: begin
          state_d = CH_WAKE;
          cnt_d   = WAKE_LOAD;
        end
        CH_STBY: if (rise_i) begin
          state_d = CH_WAKE;
          cnt_d   = ONE;
        end
        CH_WAKE: begin
          if (expired_i) state_d = CH_STBY;
          else if (rise_i) begin
            if (cnt_q <= ONE) state_d = CH_LIVE;
            else              cnt_d   = cnt_q - ONE;
          end
        end
        CH_LIVE: if (expired_i) state_d = CH_STBY;
        default: state_d = CH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  p_live_on_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == CH_LIVE) |-> $past(rise_i));
  p_stby_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == CH_STBY && rise_i && !pd_i) |=> state_q == CH_WAKE);
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
  import codec_pwr_seq_pkg::*;
#(
  parameter int STBY_TICKS      = 300000,
  parameter int CLK_LOSS_TICKS  = 20,
  parameter int TX_BLANK_FRAMES = 4,
  parameter int RX_WAKE_FRAMES  = 0,
  parameter int CLK_SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic pdn_drv_i,
  input  logic pdn_i,
  input  logic fs_tx_i,
  input  logic fs_rx_i,
  input  logic tx_mclk_i,
  input  logic rx_sig_i,
  output logic tx_act_o,
  output logic rx_act_o,
  output logic tx_oe_o,
  output logic sig_o,
  output logic sig_oe_o
);
  logic pd_req;
  logic tx_rise, tx_expired, rx_rise, rx_expired, clk_rise, tx_clk_lost;
  ch_state_e tx_st, rx_st;

  // undriven pin reads as not powered down
  assign pd_req = pdn_drv_i & ~pdn_i;

  cseq_watch #(.LIMIT(STBY_TICKS), .LOW_ONLY(1'b1), .SYNC_STAGES(0)) i_tx_watch (
    .clk_i, .rst_ni, .tick_i, .lvl_i(fs_tx_i), .rise_o(tx_rise), .expired_o(tx_expired));

  cseq_watch #(.LIMIT(STBY_TICKS), .LOW_ONLY(1'b1), .SYNC_STAGES(0)) i_rx_watch (
    .clk_i, .rst_ni, .tick_i, .lvl_i(fs_rx_i), .rise_o(rx_rise), .expired_o(rx_expired));

  cseq_watch #(.LIMIT(CLK_LOSS_TICKS), .LOW_ONLY(1'b0), .SYNC_STAGES(CLK_SYNC_STAGES)) i_clk_watch (
    .clk_i, .rst_ni, .tick_i, .lvl_i(tx_mclk_i), .rise_o(clk_rise), .expired_o(tx_clk_lost));

  cseq_chan #(.WAKE_FRAMES(TX_BLANK_FRAMES)) i_tx_chan (
    .clk_i, .rst_ni, .pd_i(pd_req), .rise_i(tx_rise), .expired_i(tx_expired), .state_o(tx_st));

  cseq_chan #(.WAKE_FRAMES(RX_WAKE_FRAMES)) i_rx_chan (
    .clk_i, .rst_ni, .pd_i(pd_req), .rise_i(rx_rise), .expired_i(rx_expired), .state_o(rx_st));

  assign tx_act_o = (tx_st == CH_WAKE) || (tx_st == CH_LIVE);
  assign rx_act_o = (rx_st == CH_WAKE) || (rx_st == CH_LIVE);
  assign tx_oe_o  = (tx_st == CH_LIVE) && !tx_clk_lost;

  always_comb begin
    sig_o    = 1'b0;
    sig_oe_o = 1'b1;
    unique case (rx_st)
      CH_LIVE: sig_o    = rx_sig_i;
      CH_STBY: sig_oe_o = (tx_st == CH_STBY);  // float only in receive-only standby
      default: ;
    endcase
  end

  p_pd_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req |=> (!tx_act_o && !rx_act_o && !tx_oe_o && sig_oe_o && !sig_o));
  p_tx_stby_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_expired && !pd_req) |=> !tx_act_o);
  p_rx_stby_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_expired && !pd_req) |=> !rx_act_o);
  p_sig_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_oe_o |-> (!rx_act_o && tx_act_o));
  p_oe_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_oe_o) |-> ($past(tx_rise) || $past(tx_clk_lost)));
  p_clk_live_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_rise |=> !tx_clk_lost);
endmodule

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int STBY  = 40;
  localparam int LOSS  = 6;
  localparam int BLANK = 4;
  localparam int FRAME = 8;

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b1;
  logic pdn_drv = 1'b1, pdn = 1'b1;
  logic man_tx = 1'b0, man_rx = 1'b0, gen_tx = 1'b0, gen_rx = 1'b0;
  logic mclk = 1'b0, mclk_run = 1'b1, rx_sig = 1'b0;
  int   ph = 0;
  logic fs_tx, fs_rx;
  logic tx_act, rx_act, tx_oe, sig, sig_oe;
  int   n_chk = 0, n_fail = 0;

  assign fs_tx = gen_tx ? (ph == 0) : man_tx;
  assign fs_rx = gen_rx ? (ph == 0) : man_rx;

  codec_pwr_seq #(
    .STBY_TICKS(STBY), .CLK_LOSS_TICKS(LOSS), .TX_BLANK_FRAMES(BLANK),
    .RX_WAKE_FRAMES(0), .CLK_SYNC_STAGES(2)
  ) i_codec_pwr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .pdn_drv_i(pdn_drv), .pdn_i(pdn),
    .fs_tx_i(fs_tx), .fs_rx_i(fs_rx), .tx_mclk_i(mclk), .rx_sig_i(rx_sig),
    .tx_act_o(tx_act), .rx_act_o(rx_act), .tx_oe_o(tx_oe), .sig_o(sig), .sig_oe_o(sig_oe));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    ph = (ph + 1) % FRAME;
    if (mclk_run) mclk = ~mclk;
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input bit do_tx, input bit do_rx);
    @(negedge clk);
    if (do_tx) man_tx = 1'b1;
    if (do_rx) man_rx = 1'b1;
    @(negedge clk);
    man_tx = 1'b0;
    man_rx = 1'b0;
    wait_neg(2);
  endtask

  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_neg(3);
    // R1 reset state
    chk(tx_act, 1'b0, "R1 tx_act");
    chk(rx_act, 1'b0, "R1 rx_act");
    chk(tx_oe,  1'b0, "R1 tx_oe");
    chk(sig_oe, 1'b1, "R1 sig_oe");
    chk(sig,    1'b0, "R1 sig");
    rst_ni = 1'b1;
    wait_neg(2);
    chk(tx_act, 1'b1, "R9 tx waking after reset");
    chk(tx_oe,  1'b0, "R9 tx blank before first rise");

    // R9 blanking: enable at rise BLANK+1
    for (int k = 1; k <= BLANK + 2; k++) begin
      pulse(1'b1, 1'b1);
      chk(tx_oe, (k >= BLANK + 1), $sformatf("R9 tx_oe after rise %0d", k));
      chk(rx_act, 1'b1, "R9 rx awake");
      chk(sig_oe, 1'b1, "R9 sig driven");
    end

    // R11 signaling passthrough
    rx_sig = 1'b1; #1;
    chk(sig, 1'b1, "R11 sig high");
    rx_sig = 1'b0; #1;
    chk(sig, 1'b0, "R11 sig low");

    gen_tx = 1'b1; gen_rx = 1'b1;
    wait_neg(40);
    chk(tx_oe, 1'b1, "R9 steady frames");

    // R10 clock loss
    mclk_run = 1'b0;
    wait_neg(2);
    chk(tx_oe, 1'b1, "R10 oe just after clock stop");
    wait_neg(12);
    chk(tx_oe, 1'b0, "R10 oe off after clock loss");
    chk(tx_act, 1'b1, "R10 tx still awake");
    mclk_run = 1'b1;
    wait_neg(6);
    chk(tx_oe, 1'b1, "R10 oe back with clock");

    // R4 exact standby threshold sweep on tx
    gen_tx = 1'b0; man_tx = 1'b0;
    for (int d = STBY - 1; d <= STBY + 3; d++) begin
      pulse(1'b1, 1'b0);
      @(negedge clk); man_tx = 1'b1;
      @(negedge clk); man_tx = 1'b0;
      wait_neg(d);
      chk(tx_act, !(d >= STBY + 2), $sformatf("R4 tx_act low %0d", d));
      chk(tx_oe,  !(d >= STBY + 2), $sformatf("R4 tx_oe low %0d", d));
    end

    // R8 wake from standby
    chk(sig_oe, 1'b1, "R5 rx unaffected by tx standby");
    pulse(1'b1, 1'b0);
    chk(tx_act, 1'b1, "R8 awake after first rise");
    chk(tx_oe,  1'b0, "R8 still blank first frame");
    pulse(1'b1, 1'b0);
    chk(tx_oe,  1'b1, "R8 outputs on at next rise");

    // R7 tick gating
    tick = 1'b0;
    wait_neg(STBY * 3);
    chk(tx_act, 1'b1, "R7 no standby without ticks");
    tick = 1'b1;
    wait_neg(STBY + 5);
    chk(tx_act, 1'b0, "R7 standby once ticks resume");
    chk(tx_oe,  1'b0, "R4 tx_oe in standby");

    // R5 receive-only standby
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    gen_tx = 1'b1; gen_rx = 1'b0; man_rx = 1'b0;
    wait_neg(STBY + 12);
    chk(rx_act, 1'b0, "R5 rx_act");
    chk(sig_oe, 1'b0, "R5 sig floats");
    chk(tx_oe,  1'b1, "R5 tx keeps working");

    // R6 both in standby
    rx_sig = 1'b1;
    gen_tx = 1'b0; man_tx = 1'b0;
    wait_neg(STBY + 12);
    chk(tx_act, 1'b0, "R6 tx_act");
    chk(tx_oe,  1'b0, "R6 tx_oe");
    chk(sig_oe, 1'b1, "R6 sig_oe");
    chk(sig,    1'b0, "R6 sig low");

    // restore
    gen_tx = 1'b1; gen_rx = 1'b1;
    wait_neg(4 * FRAME);
    chk(tx_oe, 1'b1, "R8 tx back after standby");
    chk(sig,   1'b1, "R11 sig follows input");

    // R3 undriven pin
    pdn_drv = 1'b0; pdn = 1'b0;
    wait_neg(5);
    chk(tx_oe,  1'b1, "R3 undriven keeps tx");
    chk(rx_act, 1'b1, "R3 undriven keeps rx");

    // R2 power-down
    pdn_drv = 1'b1;
    @(negedge clk);
    chk(tx_act, 1'b0, "R2 tx_act");
    chk(rx_act, 1'b0, "R2 rx_act");
    chk(tx_oe,  1'b0, "R2 tx_oe");
    chk(sig_oe, 1'b1, "R2 sig_oe");
    chk(sig,    1'b0, "R2 sig low");
    wait_neg(STBY * 2);
    chk(tx_oe,  1'b0, "R2 held in power-down");

    // R9 blanking after power-down release
    pdn = 1'b1;
    wait_neg(2 * FRAME);
    chk(tx_oe,  1'b0, "R9 blank after release");
    chk(tx_act, 1'b1, "R9 awake after release");
    wait_neg(5 * FRAME);
    chk(tx_oe,  1'b1, "R9 enabled after blanking");

    finish_run();
  end
endmodule